// File: doc/BRIEF.md
# SMII Receive Segment Serializer

This block turns one decoded receive byte per segment, together with carrier, data-valid and PHY status inputs, into the serial receive line of a Serial MII link. It runs from the link clock. A free-running modulo-10 counter cuts the output stream into 10-bit segments that follow each other with no gap. A one-cycle SYNC pulse marks the first bit of each segment.

Each segment starts with two control bits, carrier and data-valid. Eight payload bits follow. When data-valid is set, the payload is the packet byte. When it is clear, the same eight slots carry inter-frame status:

- the link state;
- a receive error that was seen during the previous frame;
- a false-carrier flag that was seen during the previous carrier event.

The two event flags are collected while carrier is up. They are made visible when carrier drops, and they are cleared when the next carrier event begins.

The upstream logic watches `byte_take_o`. In the cycle where it is high, the inputs on the ports are the ones packed into the next segment.

Top module: `smii_rx_serializer`

## Requirements
- R1: `byte_take_o` is high in one cycle of every 10. `smii_sync_o` is high for exactly one cycle, the cycle after each `byte_take_o`. The first pulse of `byte_take_o` comes in the 10th cycle after reset is released.
- R2: While reset is applied, and until the first segment starts, `smii_sync_o` and `smii_rx_o` are low.
- R3: The serial order within a segment is fixed. Bit time 0 is the carrier bit and lines up with SYNC. Bit time 1 is data-valid. Bit times 2 to 9 are payload bits 0 to 7, lowest bit first.
- R4: The carrier bit is the OR of `rx_crs_i` and `rx_dv_i`, as sampled in the `byte_take_o` cycle. A segment whose carrier bit is 0 therefore always has data-valid 0.
- R5: When data-valid is 1, the payload is `rx_data_i` as sampled in the `byte_take_o` cycle.
- R6: When data-valid is 0, the payload bits are fixed as follows:
  - bit 1 = `speed_100_i`
  - bit 2 = `full_duplex_i`
  - bit 3 = `link_up_i`
  - bit 4 = `jabber_i`
  - bit 5 = `nibble_ok_i`
  - bit 7 = 1
- R7: Payload bit 0 between frames is the reported receive error. Any `fifo_err_i` cycle during a carrier event (including the cycle that ends it) sets this bit. It takes effect from the first segment with carrier 0, and it holds until the next event starts.
- R8: Payload bit 6 between frames is the reported false carrier. It follows the same collect, report and clear rules as R7, driven by `false_carrier_i`.
- R9: The first segment of a new carrier event shows both reported flags as 0. Flag pulses that arrive while carrier is down, before the event starts, are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_crs_i | input | 1 | Medium busy (carrier) |
| rx_dv_i | input | 1 | Byte on rx_data_i is packet data |
| rx_data_i | input | 8 | Decoded receive byte |
| fifo_err_i | input | 1 | Receive FIFO overrun or underrun pulse |
| false_carrier_i | input | 1 | Bad start delimiter pulse |
| link_up_i | input | 1 | Link is up |
| speed_100_i | input | 1 | 1 = 100 Mb/s |
| full_duplex_i | input | 1 | 1 = full duplex |
| jabber_i | input | 1 | Jabber detected |
| nibble_ok_i | input | 1 | Upper nibble valid |
| byte_take_o | output | 1 | Inputs in this cycle are loaded into the next segment |
| smii_sync_o | output | 1 | Segment start pulse |
| smii_rx_o | output | 1 | Serial receive data |

## Verification
A wrong value in the segment counter moves SYNC off its 10-cycle grid. That shows at the ports within one segment and shifts every bit after it.

A wrong value in the collected or reported error flags stays hidden while data-valid is high. It only appears in payload bits 0 and 6 of the first status segment after carrier drops. For that reason the stimulus places flag pulses at the carrier rise, in the middle of a frame, in the cycle that ends the event, and during idle. The reference model compares every output bit on every clock.

// File: rtl/smii_rx_pkg.sv
package smii_rx_pkg;
  localparam int DATA_W  = 8;
  localparam int SEG_LEN = DATA_W + 2;

  // payload slot positions used while data-valid is low
  localparam int ST_ERR    = 0;
  localparam int ST_SPEED  = 1;
  localparam int ST_DUPLEX = 2;
  localparam int ST_LINK   = 3;
  localparam int ST_JABBER = 4;
  localparam int ST_NIBOK  = 5;
  localparam int ST_FCAR   = 6;
  localparam int ST_ONE    = 7;

  typedef struct packed {
    logic nib_ok;
    logic jabber;
    logic link;
    logic duplex;
    logic speed;
  } phy_stat_t;
endpackage

// File: rtl/smii_seg_timer.sv
module smii_seg_timer #(
  parameter int SEG_LEN = smii_rx_pkg::SEG_LEN
) (
  input  logic clk,
  input  logic rst,
  output logic take_o
);
  localparam int CNT_W = $clog2(SEG_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SEG_LEN - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (take_o)  cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  assign take_o = (cnt == LAST);

  AST_TAKE_WRAPS: assert property (@(posedge clk) disable iff (rst)
    take_o |=> (cnt == '0)); // R1
  AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    take_o |=> !take_o); // R1
endmodule

// File: rtl/smii_evt_status.sv
module smii_evt_status (
  input  logic clk,
  input  logic rst,
  input  logic take_i,
  input  logic crs_i,
  input  logic err_i,
  input  logic fc_i,
  output logic err_show_o,
  output logic fc_show_o
);
  logic prev_crs;
  logic acc_err, acc_fc;
  logic rep_err, rep_fc;
  logic evt_start, evt_end;

  assign evt_start = take_i &  crs_i & ~prev_crs;
  assign evt_end   = take_i & ~crs_i &  prev_crs;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_crs <= 1'b0;
      acc_err  <= 1'b0;
      acc_fc   <= 1'b0;
      rep_err  <= 1'b0;
      rep_fc   <= 1'b0;
    end else begin
      if (take_i) prev_crs <= crs_i;
      if (evt_start) begin
        acc_err <= err_i;
        acc_fc  <= fc_i;
        rep_err <= 1'b0;
        rep_fc  <= 1'b0;
      end else if (evt_end) begin
        acc_err <= 1'b0;
        acc_fc  <= 1'b0;
        rep_err <= acc_err | err_i;
        rep_fc  <= acc_fc  | fc_i;
      end else begin
        acc_err <= acc_err | err_i;
        acc_fc  <= acc_fc  | fc_i;
      end
    end
  end

  always_comb begin
    if (evt_end) begin
      err_show_o = acc_err | err_i;
      fc_show_o  = acc_fc  | fc_i;
    end else if (evt_start) begin
      err_show_o = 1'b0;
      fc_show_o  = 1'b0;
    end else begin
      err_show_o = rep_err;
      fc_show_o  = rep_fc;
    end
  end

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    evt_start |=> (!rep_err && !rep_fc)); // R9
  AST_REP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !take_i |=> ($stable(rep_err) && $stable(rep_fc))); // R7
endmodule

// File: rtl/smii_seg_build.sv
module smii_seg_build
  import smii_rx_pkg::*;
#(
  parameter int DW = smii_rx_pkg::DATA_W
) (
  input  logic             crs_i,
  input  logic             dv_i,
  input  logic [DW-1:0]    data_i,
  input  phy_stat_t        stat_i,
  input  logic             err_i,
  input  logic             fc_i,
  output logic [DW+1:0]    seg_o
);
  logic [DW-1:0] status_byte;

  always_comb begin
    status_byte            = '0;
    status_byte[ST_ERR]    = err_i;
    status_byte[ST_SPEED]  = stat_i.speed;
    status_byte[ST_DUPLEX] = stat_i.duplex;
    status_byte[ST_LINK]   = stat_i.link;
    status_byte[ST_JABBER] = stat_i.jabber;
    status_byte[ST_NIBOK]  = stat_i.nib_ok;
    status_byte[ST_FCAR]   = fc_i;
    status_byte[ST_ONE]    = 1'b1;
  end

  assign seg_o[0]      = crs_i | dv_i;
  assign seg_o[1]      = dv_i;
  assign seg_o[DW+1:2] = dv_i ? data_i : status_byte;
endmodule

// File: rtl/smii_seg_shift.sv
module smii_seg_shift #(
  parameter int SEG_LEN = smii_rx_pkg::SEG_LEN
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take_i,
  input  logic [SEG_LEN-1:0] seg_i,
  output logic               rx_o,
  output logic               sync_o
);
  logic [SEG_LEN-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      sync_o <= 1'b0;
    end else if (take_i) begin
      shreg  <= seg_i;
      sync_o <= 1'b1;
    end else begin
      shreg  <= {1'b0, shreg[SEG_LEN-1:1]};
      sync_o <= 1'b0;
    end
  end

  assign rx_o = shreg[0];

  AST_SYNC_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    take_i |=> sync_o); // R1
endmodule

// File: rtl/smii_rx_serializer.sv
module smii_rx_serializer
  import smii_rx_pkg::*;
#(
  parameter int DW = smii_rx_pkg::DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_crs_i,
  input  logic          rx_dv_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          fifo_err_i,
  input  logic          false_carrier_i,
  input  logic          link_up_i,
  input  logic          speed_100_i,
  input  logic          full_duplex_i,
  input  logic          jabber_i,
  input  logic          nibble_ok_i,
  output logic          byte_take_o,
  output logic          smii_sync_o,
  output logic          smii_rx_o
);
  localparam int SLEN = DW + 2;

  logic            take;
  logic            crs_eff;
  logic            err_show, fc_show;
  phy_stat_t       stat;
  logic [SLEN-1:0] seg;

  assign crs_eff = rx_crs_i | rx_dv_i;
  assign stat = '{nib_ok: nibble_ok_i, jabber: jabber_i, link: link_up_i,
                  duplex: full_duplex_i, speed: speed_100_i};

  smii_seg_timer #(.SEG_LEN(SLEN)) u_timer (
    .clk(clk), .rst(rst), .take_o(take));

  smii_evt_status u_status (
    .clk(clk), .rst(rst), .take_i(take), .crs_i(crs_eff),
    .err_i(fifo_err_i), .fc_i(false_carrier_i),
    .err_show_o(err_show), .fc_show_o(fc_show));

  smii_seg_build #(.DW(DW)) u_build (
    .crs_i(rx_crs_i), .dv_i(rx_dv_i), .data_i(rx_data_i), .stat_i(stat),
    .err_i(err_show), .fc_i(fc_show), .seg_o(seg));

  smii_seg_shift #(.SEG_LEN(SLEN)) u_shift (
    .clk(clk), .rst(rst), .take_i(take), .seg_i(seg),
    .rx_o(smii_rx_o), .sync_o(smii_sync_o));

  assign byte_take_o = take;

  AST_NO_DV_WITHOUT_CRS: assert property (@(posedge clk) disable iff (rst)
    (smii_sync_o && !smii_rx_o) |=> !smii_rx_o); // R4
  AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    smii_sync_o |=> !smii_sync_o); // R1
endmodule

// File: tb/sim_smii_rx_serializer.sv
module sim_smii_rx_serializer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic crs = 0, dv = 0, ferr = 0, fcar = 0;
  logic [7:0] data = 0;
  logic link = 1, spd = 1, dup = 1, jab = 0, nib = 1;
  logic take, sync, rx;

  int n_cmp = 0, n_bad = 0, cycles = 0;

  always #2.5 clk = ~clk;

  smii_rx_serializer u0 (
    .clk(clk), .rst(rst), .rx_crs_i(crs), .rx_dv_i(dv), .rx_data_i(data),
    .fifo_err_i(ferr), .false_carrier_i(fcar), .link_up_i(link),
    .speed_100_i(spd), .full_duplex_i(dup), .jabber_i(jab), .nibble_ok_i(nib),
    .byte_take_o(take), .smii_sync_o(sync), .smii_rx_o(rx));

  // behavioural reference model
  int e = 0, midx = 0;
  bit started = 0, seen_edge = 0, in_rst = 1;
  bit m_prev = 0, a_err = 0, a_fc = 0, r_err = 0, r_fc = 0;
  bit m_crs = 0, m_dv = 0;
  logic [9:0] mseg = '0;
  bit x_sync = 0, x_rx = 0, x_take = 0;

  always @(posedge clk) begin
    seen_edge = 1;
    if (rst) begin
      e = 0; started = 0; midx = 0; in_rst = 1;
      m_prev = 0; a_err = 0; a_fc = 0; r_err = 0; r_fc = 0;
      x_sync = 0; x_rx = 0;
    end else begin
      in_rst = 0;
      e = e + 1;
      if (e % 10 == 0) begin
        bit c, se, sf;
        c = crs | dv;
        if (c && !m_prev) begin
          se = 0; sf = 0; a_err = ferr; a_fc = fcar; r_err = 0; r_fc = 0;
        end else if (!c && m_prev) begin
          se = a_err | ferr; sf = a_fc | fcar;
          r_err = se; r_fc = sf; a_err = 0; a_fc = 0;
        end else begin
          se = r_err; sf = r_fc; a_err = a_err | ferr; a_fc = a_fc | fcar;
        end
        m_prev = c; m_crs = c; m_dv = dv;
        mseg[0] = c; mseg[1] = dv;
        if (dv) mseg[9:2] = data;
        else mseg[9:2] = {1'b1, sf, nib, jab, link, dup, spd, se};
        started = 1; midx = 0; x_sync = 1;
      end else begin
        a_err = a_err | ferr; a_fc = a_fc | fcar;
        if (started) midx = midx + 1;
        x_sync = 0;
      end
      x_rx = started ? mseg[midx] : 1'b0;
    end
    x_take = !rst && (e % 10 == 9);
  end

  function automatic string rx_tag();
    if (!started) return "R2";
    if (midx == 0) return "R4";
    if (midx == 1) return "R3";
    if (m_dv) return "R5";
    if (midx == 2 || midx == 8) return m_crs ? "R9" : ((midx == 2) ? "R7" : "R8");
    return "R6";
  endfunction

  always @(negedge clk) begin
    if (seen_edge) begin
      n_cmp++;
      if (sync !== x_sync) begin
        n_bad++;
        $display("FAIL %s sync: actual %b expected %b at cycle %0d",
                 (in_rst || !started) ? "R2" : "R1", sync, x_sync, cycles);
      end
      n_cmp++;
      if (rx !== x_rx) begin
        n_bad++;
        $display("FAIL %s rx bit %0d: actual %b expected %b at cycle %0d",
                 rx_tag(), midx, rx, x_rx, cycles);
      end
      n_cmp++;
      if (take !== x_take) begin
        n_bad++;
        $display("FAIL R1 take: actual %b expected %b at cycle %0d", take, x_take, cycles);
      end
    end
  end

  // one segment of stimulus; pulse positions >= 10 mean no pulse
  task automatic seg(input bit c, input bit v, input logic [7:0] d,
                     input int ep, input int fp);
    for (int i = 0; i < 10; i++) begin
      crs = c; dv = v; data = d;
      ferr = (i == ep); fcar = (i == fp);
      @(negedge clk);
    end
    ferr = 0; fcar = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();                                  // R2 checked while idle
    seg(0, 0, 8'h00, 99, 99);
    spd = 0; dup = 0; jab = 1; nib = 0;          // R6 pattern A
    seg(0, 0, 8'h00, 99, 99);
    spd = 1; dup = 1; jab = 0; nib = 1; link = 0; // R6 pattern B
    seg(0, 0, 8'h00, 4, 99);                     // R9 idle pulse discarded
    link = 1;
    // frame with an error pulse at the start edge and mid frame (R5, R7)
    seg(1, 1, 8'h55, 9, 99);
    seg(1, 1, 8'hD5, 99, 99);
    seg(1, 1, 8'hA3, 3, 99);
    seg(1, 1, 8'h3C, 99, 99);
    seg(1, 0, 8'h00, 99, 99);                    // carrier tail, status shown
    seg(0, 0, 8'h00, 99, 99);                    // R7 error reported
    seg(0, 0, 8'h00, 99, 99);
    // false carrier event (R8, R9)
    seg(1, 0, 8'h00, 99, 2);
    seg(1, 0, 8'h00, 99, 99);
    seg(0, 0, 8'h00, 99, 99);
    seg(0, 0, 8'h00, 99, 99);
    // data-valid without carrier forces the carrier bit (R4)
    seg(0, 1, 8'h81, 99, 99);
    seg(0, 1, 8'h7E, 99, 99);
    seg(0, 0, 8'h00, 9, 99);                     // pulse in the ending cycle
    seg(0, 0, 8'h00, 99, 99);
    // frame with no error clears the report
    seg(1, 1, 8'hFF, 99, 99);
    seg(1, 1, 8'h00, 99, 99);
    seg(0, 0, 8'h00, 99, 9);
    seg(0, 0, 8'h00, 99, 99);
    // reset in the middle of a frame
    seg(1, 1, 8'h96, 99, 99);
    crs = 1; dv = 1; data = 8'h69;
    repeat (4) @(negedge clk);
    do_reset();
    seg(0, 0, 8'h00, 99, 99);
    seg(1, 1, 8'hC3, 99, 99);
    seg(0, 0, 8'h00, 99, 99);
    seg(0, 0, 8'h00, 99, 99);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end
endmodule